// File: doc/BRIEF.md
# Smart Card Character Receive Sampler

This block is the receive front end of an asynchronous character link of the kind used by smart cards. Bit timing comes only from a basic-clock enable that the surrounding logic generates internally; no external transfer clock is taken. Each bit lasts N enable ticks. In smart card mode a two-bit select sets N to 32, 64, 372 or 256. In normal asynchronous mode N is always 16.

The receive line first passes through a two-flop synchronizer. While the receiver is idle, a falling edge seen on an enable tick restarts the bit-phase counter, and this is the synchronization point. Every bit is then sampled when the phase counter reaches N/2, which is the middle of the bit. For N = 372 that point is count 186, and the counter wraps after 371. A character is ten bits long: a low start bit, eight data bits sent LSB first, and an even parity bit.

When the parity bit has been sampled, the byte is presented together with a single-cycle strobe and a parity error flag. If the start bit reads high at its midpoint, the event is treated as a false start. The block then pulses a framing error flag and goes back to idle without delivering a byte.

Top module: `sc_rx_sampler`

## Requirements
- R1: While reset is held and after it is released, `rx_valid`, `rx_parity_err` and `rx_frame_err` are 0 and `rx_data` is 0.
- R2: A reception starts only on a high-to-low change of the synchronized line, seen between two enable ticks while the receiver is idle. A line that stays low does not start another reception.
- R3: In smart card mode (`sc_mode`=1), `ratio_sel` sets N as follows: 00 gives 32, 01 gives 64, 10 gives 372 and 11 gives 256 enable ticks per bit.
- R4: In normal mode (`sc_mode`=0), N is 16 for every value of `ratio_sel`.
- R5: Counting the synchronization tick as tick 0, bit k (start bit = 0) is sampled on tick k*N + N/2.
- R6: Bits 1 to 8 form the data byte with bit 1 as the LSB. On the clock after the parity sample, `rx_valid` is high for exactly one cycle and `rx_data` holds the byte until the next character arrives.
- R7: `rx_parity_err` is 1 together with `rx_valid` exactly when the number of ones in the data and parity bits is odd. It is 0 at all other times.
- R8: If the start bit samples high, `rx_frame_err` pulses for one cycle, no `rx_valid` follows, and the receiver is idle again.
- R9: A change of `sc_mode` or `ratio_sel` during a character has no effect on that character's timing.
- R10: Only enable ticks advance the bit timing. With `bclk_en` high on one clock out of several, characters are still received correctly at N ticks per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_en | input | 1 | Basic-clock enable tick |
| rxd_in | input | 1 | Asynchronous receive line, idles high |
| sc_mode | input | 1 | 1 = smart card ratios, 0 = fixed 16x |
| ratio_sel | input | 2 | Ratio select used in smart card mode |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe when a byte is received |
| rx_parity_err | output | 1 | Parity mismatch, qualified by rx_valid |
| rx_frame_err | output | 1 | One-cycle pulse on a false start bit |

## Verification
A phase counter that drifts, or a wrong ratio latched at the sync point, moves the sample instants. Within the first character this shows up as a wrong byte, a wrong parity flag, or a strobe on the wrong clock, and the per-clock comparison against the bench model catches it on that exact cycle. A start detector left armed during reception does not fail at once: it shows up as an extra or a missing strobe, a frame error, or a shifted byte on the next character. It is exposed by changing the select in the middle of a character and by holding the line low after a zero parity bit.

// File: rtl/sc_rx_pkg.sv
// Package: shared constants, state type and ratio decode for the receiver.
// Assumes ratios fit in CNT_W bits; largest ratio is 372.
package sc_rx_pkg;
    localparam int RATIO_NORM = 16;
    localparam int RATIO_S0   = 32;
    localparam int RATIO_S1   = 64;
    localparam int RATIO_S2   = 372;
    localparam int RATIO_S3   = 256;
    localparam int RATIO_MAX  = 372;
    localparam int CNT_W      = $clog2(RATIO_MAX + 1);

    typedef enum logic {ST_IDLE = 1'b0, ST_RECV = 1'b1} rx_state_t;

    // Decode mode and select into ticks per bit.
    function automatic logic [CNT_W-1:0] ratio_of(input logic smart, input logic [1:0] sel);
        if (!smart) return CNT_W'(RATIO_NORM);
        case (sel)
            2'b00:   return CNT_W'(RATIO_S0);
            2'b01:   return CNT_W'(RATIO_S1);
            2'b10:   return CNT_W'(RATIO_S2);
            default: return CNT_W'(RATIO_S3);
        endcase
    endfunction
endpackage

// File: rtl/sc_rx_sync.sv
// Module: multi-stage synchronizer for the asynchronous receive line.
// Assumes the line idles at RESET_VAL; output lags input by STAGES clocks.
module sc_rx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    // Shift the line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d_in};
    end

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/sc_rx_ratio.sv
// Module: holds the ticks-per-bit ratio, reloading it only while idle.
// Assumes busy rises on the same edge as the sync point, so the ratio
// seen at that edge governs the whole character.
module sc_rx_ratio
    import sc_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             smart,
    input  logic [1:0]       sel,
    output logic [CNT_W-1:0] n_q,
    output logic [CNT_W-1:0] half_q
);
    // Track the selection while idle, freeze it during reception.
    always_ff @(posedge clk) begin
        if (!rst_n)    n_q <= CNT_W'(RATIO_NORM);
        else if (!busy) n_q <= ratio_of(smart, sel);
    end

    assign half_q = n_q >> 1;

    // R9: ratio must not move while a character is in progress.
    a_r9_ratio_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(n_q));
endmodule

// File: rtl/sc_rx_phase.sv
// Module: bit-phase counter, 0..n-1 per bit, restarted at the sync point.
// Assumes n >= 2; emits mid-bit and bit-wrap strobes on enable ticks.
module sc_rx_phase
    import sc_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic             run,
    input  logic [CNT_W-1:0] n,
    input  logic [CNT_W-1:0] half,
    output logic             mid_hit,
    output logic             bit_wrap
);
    logic [CNT_W-1:0] phase;
    logic [CNT_W-1:0] phase_nxt;

    // Next count with wrap after n-1.
    always_comb begin
        phase_nxt = (phase == n - CNT_W'(1)) ? '0 : phase + CNT_W'(1);
    end

    // Advance the count on each enable tick during reception.
    always_ff @(posedge clk) begin
        if (!rst_n)            phase <= '0;
        else if (tick) begin
            if (restart)       phase <= '0;
            else if (run)      phase <= phase_nxt;
        end
    end

    assign mid_hit  = tick && run && (phase_nxt == half);
    assign bit_wrap = tick && run && (phase_nxt == '0);

    // R5: counter never leaves 0..n-1 while receiving.
    a_r5_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (phase < n));
    // R5: midpoint and boundary never coincide.
    a_r5_mid_not_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mid_hit && bit_wrap));
endmodule

// File: rtl/sc_rx_sampler.sv
// Module: smart card character receiver; start detect, mid-bit sampling,
// byte assembly, even-parity check and false-start reporting.
// Assumes bclk_en is a one-clock pulse at the basic clock rate.
module sc_rx_sampler
    import sc_rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bclk_en,
    input  logic                 rxd_in,
    input  logic                 sc_mode,
    input  logic [1:0]           ratio_sel,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 rx_parity_err,
    output logic                 rx_frame_err
);
    localparam int FRAME_BITS = DATA_BITS + 2;
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

    rx_state_t             state;
    logic                  rxd_s;
    logic                  rx_prev;
    logic                  busy;
    logic                  sync_hit;
    logic                  mid_hit;
    logic                  bit_wrap;
    logic [CNT_W-1:0]      n_q;
    logic [CNT_W-1:0]      half_q;
    logic [BIT_W-1:0]      bit_idx;
    logic [DATA_BITS-1:0]  shreg;

    assign busy     = (state == ST_RECV);
    assign sync_hit = bclk_en && !busy && rx_prev && !rxd_s;

    sc_rx_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(rxd_in), .d_out(rxd_s)
    );

    sc_rx_ratio u_ratio (
        .clk(clk), .rst_n(rst_n), .busy(busy), .smart(sc_mode),
        .sel(ratio_sel), .n_q(n_q), .half_q(half_q)
    );

    sc_rx_phase u_phase (
        .clk(clk), .rst_n(rst_n), .tick(bclk_en), .restart(sync_hit),
        .run(busy), .n(n_q), .half(half_q),
        .mid_hit(mid_hit), .bit_wrap(bit_wrap)
    );

    // Remember the line value at the previous enable tick for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_prev <= 1'b1;
        else if (bclk_en) rx_prev <= rxd_s;
    end

    // Receive state machine, bit index and data shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
            shreg   <= '0;
        end else if (sync_hit) begin
            state   <= ST_RECV;
            bit_idx <= '0;
        end else if (busy) begin
            if (bit_wrap) bit_idx <= bit_idx + BIT_W'(1);
            if (mid_hit) begin
                if (bit_idx == '0) begin
                    if (rxd_s) state <= ST_IDLE;
                end else if (bit_idx == LAST_BIT) begin
                    state <= ST_IDLE;
                end else begin
                    shreg <= {rxd_s, shreg[DATA_BITS-1:1]};
                end
            end
        end
    end

    // Output strobes and byte capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data       <= '0;
            rx_valid      <= 1'b0;
            rx_parity_err <= 1'b0;
            rx_frame_err  <= 1'b0;
        end else begin
            rx_valid      <= 1'b0;
            rx_parity_err <= 1'b0;
            rx_frame_err  <= 1'b0;
            if (busy && mid_hit) begin
                if (bit_idx == '0 && rxd_s) begin
                    rx_frame_err <= 1'b1;
                end else if (bit_idx == LAST_BIT) begin
                    rx_data       <= shreg;
                    rx_valid      <= 1'b1;
                    rx_parity_err <= ^{shreg, rxd_s};
                end
            end
        end
    end

    // R2: a reception begins only after a high-to-low change of the line.
    a_r2_start_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!$past(rxd_s) && $past(rx_prev)));
    // R6: the byte strobe lasts one cycle.
    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R7: parity flag only accompanies a byte strobe.
    a_r7_perr_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        rx_parity_err |-> rx_valid);
    // R8: a false start never delivers a byte at the same time.
    a_r8_ferr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_frame_err && rx_valid));
    // R8: after a false start the receiver is idle.
    a_r8_idle_after_ferr: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_err |-> !busy);
endmodule

// File: tb/sc_rx_sampler_bench.sv
module sc_rx_sampler_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk_en = 1'b0;
    logic       rxd_in = 1'b1;
    logic       sc_mode = 1'b1;
    logic [1:0] ratio_sel = 2'b00;
    logic [7:0] rx_data;
    logic       rx_valid, rx_parity_err, rx_frame_err;

    int n_vec = 0;
    int n_bad = 0;
    int en_div = 1;
    bit done = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_rx_sampler u_sc_rx_sampler (
        .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .rxd_in(rxd_in),
        .sc_mode(sc_mode), .ratio_sel(ratio_sel), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_parity_err(rx_parity_err),
        .rx_frame_err(rx_frame_err)
    );

    // Ticks per bit from the requirements (R3, R4).
    function automatic int ref_ratio(input logic smart, input logic [1:0] sel);
        if (!smart) return 16;
        case (sel)
            2'b00: return 32;
            2'b01: return 64;
            2'b10: return 372;
            default: return 256;
        endcase
    endfunction

    // Behavioural reference model: integer tick count since sync.
    logic m_s1 = 1, m_s2 = 1, m_prev = 1, m_busy = 0;
    int   m_t = 0, m_n = 16, nt, bi;
    logic [9:0] m_bits;
    logic [7:0] e_data = 0;
    logic e_valid = 0, e_perr = 0, e_ferr = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 1; m_s2 <= 1; m_prev <= 1; m_busy <= 0; m_t <= 0;
            e_data <= 0; e_valid <= 0; e_perr <= 0; e_ferr <= 0;
        end else begin
            m_s1 <= rxd_in; m_s2 <= m_s1;
            e_valid <= 0; e_perr <= 0; e_ferr <= 0;
            if (!m_busy) m_n <= ref_ratio(sc_mode, ratio_sel);
            if (bclk_en) begin
                m_prev <= m_s2;
                if (!m_busy) begin
                    if (m_prev && !m_s2) begin m_busy <= 1; m_t <= 0; end
                end else begin
                    nt = m_t + 1;
                    m_t <= nt;
                    if (nt % m_n == m_n / 2) begin
                        bi = nt / m_n;
                        m_bits[bi] = m_s2;
                        if (bi == 0 && m_s2) begin
                            e_ferr <= 1; m_busy <= 0;
                        end else if (bi == 9) begin
                            e_data  <= m_bits[8:1];
                            e_valid <= 1;
                            e_perr  <= ^m_bits[9:1];
                            m_busy  <= 0;
                        end
                    end
                end
            end
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_vec++;
            if ({rx_data, rx_valid, rx_parity_err, rx_frame_err} !==
                {e_data, e_valid, e_perr, e_ferr}) begin
                n_bad++;
                $display("FAIL %s t=%0t got data=%h v=%b pe=%b fe=%b exp data=%h v=%b pe=%b fe=%b",
                    cur_req, $time, rx_data, rx_valid, rx_parity_err, rx_frame_err,
                    e_data, e_valid, e_perr, e_ferr);
            end
        end
    end

    // Event monitor for direct, model-free checks.
    int ev_valid = 0, ev_ferr = 0;
    logic [7:0] last_data = 0;
    logic last_perr = 0;
    always @(negedge clk) begin
        if (rx_valid) begin ev_valid++; last_data = rx_data; last_perr = rx_parity_err; end
        if (rx_frame_err) ev_ferr++;
    end

    task automatic check(input string req, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    // Enable tick generator: one clock out of en_div.
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            bclk_en = (c == 0);
            c = (c + 1 >= en_div) ? 0 : c + 1;
        end
    end

    // Send one character: start, data LSB first, parity (optionally flipped).
    task automatic send(input logic [7:0] d, input bit flip, input int n_ticks);
        logic [9:0] fr;
        int per;
        per = n_ticks * en_div;
        fr = {(^d) ^ flip, d, 1'b0};
        for (int i = 0; i < 10; i++) begin
            rxd_in = fr[i];
            repeat (per) @(negedge clk);
        end
        rxd_in = 1'b1;
        repeat (2 * per) @(negedge clk);
    endtask

    task automatic rx_expect(input string req, input logic [7:0] d, input bit perr, input int nv);
        check(req, ev_valid, nv);
        check(req, last_data, d);
        check(req, last_perr, perr);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {rx_data, rx_valid, rx_parity_err, rx_frame_err}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1", {rx_valid, rx_frame_err}, 0);

        // R3/R5/R6: ratio 32
        cur_req = "R3"; sc_mode = 1; ratio_sel = 2'b00;
        send(8'hA5, 0, 32); rx_expect("R6", 8'hA5, 0, 1);
        send(8'h3C, 0, 32); rx_expect("R5", 8'h3C, 0, 2);
        // R7: ratio 64 with bad parity
        cur_req = "R7"; ratio_sel = 2'b01;
        send(8'h81, 1, 64); rx_expect("R7", 8'h81, 1, 3);
        // R3: ratio 372 and 256
        cur_req = "R3"; ratio_sel = 2'b10;
        send(8'h5A, 0, 372); rx_expect("R3", 8'h5A, 0, 4);
        ratio_sel = 2'b11;
        send(8'hFF, 0, 256); rx_expect("R3", 8'hFF, 0, 5);
        // R4: normal mode ignores select
        cur_req = "R4"; sc_mode = 0; ratio_sel = 2'b10;
        send(8'h96, 0, 16); rx_expect("R4", 8'h96, 0, 6);
        ratio_sel = 2'b01;
        send(8'h01, 1, 16); rx_expect("R4", 8'h01, 1, 7);
        // R8: false start
        cur_req = "R8"; sc_mode = 1; ratio_sel = 2'b00;
        rxd_in = 0; repeat (6) @(negedge clk); rxd_in = 1;
        repeat (200) @(negedge clk);
        check("R8", ev_ferr, 1); check("R8", ev_valid, 7);
        send(8'h42, 0, 32); rx_expect("R8", 8'h42, 0, 8);
        // R2: zero byte, line held low after it
        cur_req = "R2";
        begin
            logic [9:0] fr = {1'b0, 8'h00, 1'b0};
            for (int i = 0; i < 10; i++) begin rxd_in = fr[i]; repeat (32) @(negedge clk); end
            repeat (32 * 12) @(negedge clk);
            check("R2", ev_valid, 9); check("R2", ev_ferr, 1);
            rxd_in = 1; repeat (64) @(negedge clk);
            check("R2", ev_valid, 9);
        end
        // R9: select changes mid-character
        cur_req = "R9";
        fork
            send(8'hC3, 0, 32);
            begin repeat (100) @(negedge clk); ratio_sel = 2'b10; sc_mode = 1; end
        join
        rx_expect("R9", 8'hC3, 0, 10);
        // R10: sparse enable ticks
        cur_req = "R10"; ratio_sel = 2'b01; en_div = 3;
        repeat (10) @(negedge clk);
        send(8'h6E, 0, 64); rx_expect("R10", 8'h6E, 0, 11);
        check("R10", ev_ferr, 1);
        summary();
    end
endmodule